// File: doc/BRIEF.md
# Fixed-Point Rounding and Saturation Unit

This block serves the fixed-point datapath of a vector lane. For one element it works out the rounding increment that a right shift of that element needs under a 2-bit rounding mode. Separately, it narrows a wide intermediate result to the current element width, either as a signed or as an unsigned value, clamping when the value does not fit. The effective shift amount is taken from a raw shift operand according to the element width. The surrounding pipeline supplies the operands and chooses the arithmetic. It adds the increment to the shifted element and writes back the narrowed value.

The increment, the effective shift amount and the narrowed value are combinational functions of the inputs in the same cycle. The only state is a sticky saturation indicator. It is set on the clock edge after any cycle in which the narrowing clamps, and it stays set until an explicit clear.

Top module: `fxp_round_sat`

## Requirements
- R1: The element width select `sew_i` is coded 00=8, 01=16, 10=32, 11=64 bits. `shamt_o` equals the low log2(width) bits of `shift_op_i`, zero-extended.
- R2: When the effective shift amount is 0, `incr_o` is 0 in every rounding mode.
- R3: Mode 00 (nearest, ties up): `incr_o` equals element bit [s-1], where s is the effective shift amount.
- R4: Mode 01 (nearest, ties to even): `incr_o` is 1 exactly when bit [s-1] is 1 and at least one of bit [s] or any bit of [s-2:0] is 1.
- R5: Mode 10 (truncate): `incr_o` is always 0.
- R6: Mode 11 (jam to odd): `incr_o` is 1 exactly when bit [s] is 0 and at least one bit of [s-1:0] is 1.
- R7: When `is_signed_i` is 0, a `wide_i` read as unsigned that exceeds 2^m-1 (m = element width) gives `narrow_o` = m ones and counts as a clamp.
- R8: When `is_signed_i` is 1, a `wide_i` read as two's complement above 2^(m-1)-1 gives a 0 followed by m-1 ones. A value below -2^(m-1) gives a 1 followed by m-1 zeros. Both count as a clamp.
- R9: Without a clamp, `narrow_o` holds the low m bits of `wide_i`. Bits of `narrow_o` at and above position m are always 0.
- R10: `sat_flag_o` becomes 1 on the rising clock edge that ends a cycle with a clamp, and otherwise keeps its value.
- R11: `sat_flag_o` is cleared by `rst` and by `sat_clr_i` at the next rising edge. A clamp in the same cycle as `sat_clr_i` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sew_i | input | 2 | Element width select |
| rmode_i | input | 2 | Rounding mode |
| elem_i | input | ELEM_W | Element value to be shifted right |
| shift_op_i | input | ELEM_W | Raw shift operand |
| is_signed_i | input | 1 | 1 selects signed narrowing, 0 unsigned |
| wide_i | input | WIDE_W | Wide intermediate value to narrow |
| sat_clr_i | input | 1 | Clears the sticky saturation indicator |
| shamt_o | output | log2(ELEM_W) | Effective shift amount |
| incr_o | output | 1 | Rounding increment |
| narrow_o | output | ELEM_W | Narrowed (possibly clamped) value |
| sat_flag_o | output | 1 | Sticky saturation indicator |

## Verification
The rounding logic is first driven with halfway patterns, where the guard bit is set and all lower bits are clear. These are tried with the kept bit both odd and even, which separates ties-up from ties-to-even and shows when jam-to-odd leaves an odd result alone. Saturation is probed one step either side of each limit, for both signs and at the narrowest and widest element widths, which separates clamping from pass-through. The sticky indicator is driven through set, hold, clear, and a clear in the same cycle as a clamp. Several thousand random cycles follow, with the wide value arithmetically shifted so that it lands both inside and outside range. All four outputs are compared each cycle with a behavioural model.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [1:0] {
        SEW_8  = 2'b00,
        SEW_16 = 2'b01,
        SEW_32 = 2'b10,
        SEW_64 = 2'b11
    } sew_e;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'b00,
        RM_NEAR_EVEN = 2'b01,
        RM_TRUNC     = 2'b10,
        RM_JAM_ODD   = 2'b11
    } rmode_e;

    // Bits around the shift boundary that decide the increment.
    typedef struct packed {
        logic keep;     // lowest bit that survives the shift
        logic guard;    // highest bit shifted out
        logic sticky;   // OR of shifted-out bits below the guard
        logic any_out;  // OR of all shifted-out bits
    } rnd_bits_t;

    typedef struct packed {
        logic over;
        logic under;
    } clamp_t;

    function automatic int unsigned sew_width(sew_e s);
        return 32'd8 << s;
    endfunction

endpackage

// File: rtl/fxp_shamt.sv
module fxp_shamt
    import fxp_pkg::*;
#(
    parameter int ELEM_W = 64,
    localparam int SHW   = $clog2(ELEM_W)
) (
    input  sew_e              sew,
    input  logic [ELEM_W-1:0] shift_op,
    output logic [SHW-1:0]    shamt
);
    logic [SHW-1:0] keep_mask;

    always_comb begin
        keep_mask = SHW'(sew_width(sew) - 1);
        shamt     = shift_op[SHW-1:0] & keep_mask;
    end
endmodule

// File: rtl/fxp_round_incr.sv
module fxp_round_incr
    import fxp_pkg::*;
#(
    parameter int ELEM_W = 64,
    localparam int SHW   = $clog2(ELEM_W)
) (
    input  logic [ELEM_W-1:0] elem,
    input  logic [SHW-1:0]    shamt,
    input  rmode_e            rmode,
    output logic              incr
);
    logic [ELEM_W-1:0] out_mask;
    rnd_bits_t         rb;

    always_comb begin
        out_mask   = (ELEM_W'(1) << shamt) - ELEM_W'(1);
        rb.keep    = elem[shamt];
        rb.guard   = 1'b0;
        if (shamt != '0) rb.guard = elem[shamt - 1'b1];
        rb.sticky  = |(elem & (out_mask >> 1));
        rb.any_out = |(elem & out_mask);

        unique case (rmode)
            RM_NEAR_UP:   incr = rb.guard;
            RM_NEAR_EVEN: incr = rb.guard & (rb.sticky | rb.keep);
            RM_TRUNC:     incr = 1'b0;
            RM_JAM_ODD:   incr = ~rb.keep & rb.any_out;
            default:      incr = 1'b0;
        endcase
        if (shamt == '0) incr = 1'b0;
    end
endmodule

// File: rtl/fxp_saturate.sv
module fxp_saturate
    import fxp_pkg::*;
#(
    parameter int ELEM_W = 64,
    parameter int WIDE_W = 128
) (
    input  logic [WIDE_W-1:0] wide,
    input  sew_e              sew,
    input  logic              is_signed,
    output logic [ELEM_W-1:0] narrow,
    output clamp_t            clamp
);
    logic [WIDE_W-1:0] low_ones;   // m ones
    logic [WIDE_W-1:0] sign_field; // bits [WIDE_W-1:m-1]
    logic [WIDE_W-1:0] upper;
    logic [ELEM_W-1:0] emask;
    logic              fits_s;

    always_comb begin
        low_ones   = (WIDE_W'(1) << sew_width(sew)) - WIDE_W'(1);
        sign_field = ~(low_ones >> 1);
        emask      = low_ones[ELEM_W-1:0];
        clamp      = '0;

        if (is_signed) begin
            upper       = wide & sign_field;
            fits_s      = (upper == '0) || (upper == sign_field);
            clamp.over  = ~fits_s & ~wide[WIDE_W-1];
            clamp.under = ~fits_s &  wide[WIDE_W-1];
        end else begin
            upper       = wide & ~low_ones;
            fits_s      = 1'b1;
            clamp.over  = |upper;
        end

        if (clamp.over)
            narrow = is_signed ? (emask >> 1) : emask;
        else if (clamp.under)
            narrow = emask & ~(emask >> 1);
        else
            narrow = wide[ELEM_W-1:0] & emask;
    end
endmodule

// File: rtl/fxp_sat_flag.sv
module fxp_sat_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_set_next_R10: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);
    assert_rise_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set));
    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr && !set |=> !flag);
endmodule

// File: rtl/fxp_round_sat.sv
module fxp_round_sat
    import fxp_pkg::*;
#(
    parameter int ELEM_W = 64,
    parameter int WIDE_W = 128,
    localparam int SHW   = $clog2(ELEM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sew_i,
    input  logic [1:0]        rmode_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic [ELEM_W-1:0] shift_op_i,
    input  logic              is_signed_i,
    input  logic [WIDE_W-1:0] wide_i,
    input  logic              sat_clr_i,
    output logic [SHW-1:0]    shamt_o,
    output logic              incr_o,
    output logic [ELEM_W-1:0] narrow_o,
    output logic              sat_flag_o
);
    sew_e   sew;
    rmode_e rmode;
    clamp_t clamp;

    assign sew   = sew_e'(sew_i);
    assign rmode = rmode_e'(rmode_i);

    fxp_shamt #(.ELEM_W(ELEM_W)) u_shamt (
        .sew      (sew),
        .shift_op (shift_op_i),
        .shamt    (shamt_o)
    );

    fxp_round_incr #(.ELEM_W(ELEM_W)) u_incr (
        .elem  (elem_i),
        .shamt (shamt_o),
        .rmode (rmode),
        .incr  (incr_o)
    );

    fxp_saturate #(.ELEM_W(ELEM_W), .WIDE_W(WIDE_W)) u_sat (
        .wide      (wide_i),
        .sew       (sew),
        .is_signed (is_signed_i),
        .narrow    (narrow_o),
        .clamp     (clamp)
    );

    fxp_sat_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (clamp.over | clamp.under),
        .clr  (sat_clr_i),
        .flag (sat_flag_o)
    );

    assert_shamt_range_R1: assert property (@(posedge clk) disable iff (rst)
        shamt_o <= SHW'(sew_width(sew) - 1));
    assert_zero_shift_R2: assert property (@(posedge clk) disable iff (rst)
        shamt_o == '0 |-> !incr_o);
    assert_trunc_R5: assert property (@(posedge clk) disable iff (rst)
        rmode == RM_TRUNC |-> !incr_o);
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (narrow_o >> sew_width(sew)) == '0);
    assert_clamp_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(clamp.over && clamp.under));
endmodule

// File: tb/tb_fxp_round_sat.sv
`timescale 1ns/1ps
module tb_fxp_round_sat;
    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   sew_i, rmode_i;
    logic [63:0]  elem_i, shift_op_i;
    logic         is_signed_i, sat_clr_i;
    logic [127:0] wide_i;
    logic [5:0]   shamt_o;
    logic         incr_o, sat_flag_o;
    logic [63:0]  narrow_o;

    int checks = 0;
    int errors = 0;
    bit mflag  = 1'b0;

    always #2 clk = ~clk;

    fxp_round_sat dut (
        .clk(clk), .rst(rst), .sew_i(sew_i), .rmode_i(rmode_i),
        .elem_i(elem_i), .shift_op_i(shift_op_i), .is_signed_i(is_signed_i),
        .wide_i(wide_i), .sat_clr_i(sat_clr_i), .shamt_o(shamt_o),
        .incr_o(incr_o), .narrow_o(narrow_o), .sat_flag_o(sat_flag_o)
    );

    function automatic int ref_shamt(logic [1:0] s, logic [63:0] op);
        longint unsigned w = 64'd8 << s;
        return int'(op % w);
    endfunction

    function automatic bit ref_incr(logic [1:0] mode, logic [63:0] e, int s);
        bit g, below, odd;
        if (s == 0) return 1'b0;
        g = e[s-1];
        below = 1'b0;
        for (int i = 0; i < s - 1; i++) if (e[i]) below = 1'b1;
        odd = e[s];
        case (mode)
            2'b00: return g;
            2'b01: return g && (below || odd);
            2'b10: return 1'b0;
            default: return !odd && (g || below);
        endcase
    endfunction

    task automatic ref_sat(input logic [127:0] w, input logic [1:0] s, input bit sgn,
                           output logic [63:0] val, output bit clamped);
        int m = 8 << s;
        logic [63:0] lm = (m == 64) ? '1 : ((64'd1 << m) - 64'd1);
        logic signed [127:0] ws = w;
        logic signed [127:0] mx = (128'sd1 <<< (m - 1)) - 128'sd1;
        logic signed [127:0] mn = -mx - 128'sd1;
        clamped = 1'b0;
        if (sgn) begin
            if (ws > mx) begin val = mx[63:0] & lm; clamped = 1'b1; end
            else if (ws < mn) begin val = mn[63:0] & lm; clamped = 1'b1; end
            else val = w[63:0] & lm;
        end else begin
            if (w > {64'd0, lm}) begin val = lm; clamped = 1'b1; end
            else val = w[63:0] & lm;
        end
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock with the current inputs, then compare everything.
    task automatic cyc();
        int s;
        bit ei, cl;
        logic [63:0] nv;
        string itag, ntag;
        @(posedge clk);
        @(negedge clk);
        ref_sat(wide_i, sew_i, is_signed_i, nv, cl);
        if (rst) mflag = 1'b0;
        else     mflag = cl | (mflag & ~sat_clr_i);
        s  = ref_shamt(sew_i, shift_op_i);
        ei = ref_incr(rmode_i, elem_i, s);
        if (s == 0)                itag = "R2";
        else if (rmode_i == 2'b00) itag = "R3";
        else if (rmode_i == 2'b01) itag = "R4";
        else if (rmode_i == 2'b10) itag = "R5";
        else                       itag = "R6";
        if (!cl)              ntag = "R9";
        else if (is_signed_i) ntag = "R8";
        else                  ntag = "R7";
        chk("R1 shamt", 64'(shamt_o), 64'(s));
        chk({itag, " incr"}, 64'(incr_o), 64'(ei));
        chk({ntag, " narrow"}, narrow_o, nv);
        chk((rst || sat_clr_i) ? "R11 flag" : "R10 flag", 64'(sat_flag_o), 64'(mflag));
    endtask

    task automatic drive(logic [1:0] s, logic [1:0] m, logic [63:0] e, logic [63:0] op,
                         bit sg, logic [127:0] w, bit clr);
        sew_i = s; rmode_i = m; elem_i = e; shift_op_i = op;
        is_signed_i = sg; wide_i = w; sat_clr_i = clr;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sew_i = 0; rmode_i = 0; elem_i = 0; shift_op_i = 0;
        is_signed_i = 0; wide_i = 0; sat_clr_i = 0;
        // R11: reset state, even with a clamping input held
        drive(2'b00, 2'b00, 0, 0, 0, 128'd300, 0);
        drive(2'b00, 2'b00, 0, 0, 0, 128'd300, 0);
        rst = 1'b0;
        drive(2'b00, 2'b00, 0, 0, 0, 128'd0, 0);
        // R1: shift extraction per width
        drive(2'b00, 2'b00, 64'hFF, 64'hFF, 0, 0, 0);
        drive(2'b01, 2'b00, 64'hFFFF, 64'h1234, 0, 0, 0);
        drive(2'b11, 2'b01, 64'h4000_0000_0000_0000, '1, 0, 0, 0);
        // R2: zero shift with all-ones element, every mode
        for (int md = 0; md < 4; md++) drive(2'b10, 2'(md), '1, 64'h20, 0, 0, 0);
        // R3-R6: halfway ties with odd and even kept bit, plus sticky-only case
        for (int md = 0; md < 4; md++) drive(2'b00, 2'(md), 64'h18, 64'd4, 0, 0, 0);
        for (int md = 0; md < 4; md++) drive(2'b00, 2'(md), 64'h08, 64'd4, 0, 0, 0);
        for (int md = 0; md < 4; md++) drive(2'b00, 2'(md), 64'h09, 64'd4, 0, 0, 0);
        for (int md = 0; md < 4; md++) drive(2'b00, 2'(md), 64'h03, 64'd4, 0, 0, 0);
        // R7/R8/R9 and R10/R11: limits and flag sequencing
        drive(2'b00, 2'b00, 0, 0, 0, 128'd255, 1);
        drive(2'b00, 2'b00, 0, 0, 0, 128'd256, 0);
        drive(2'b00, 2'b00, 0, 0, 1, 128'd127, 0);
        drive(2'b00, 2'b00, 0, 0, 1, 128'd0, 1);
        drive(2'b00, 2'b00, 0, 0, 1, 128'd128, 0);
        drive(2'b00, 2'b00, 0, 0, 1, -128'sd128, 1);
        drive(2'b00, 2'b00, 0, 0, 1, -128'sd129, 1);
        drive(2'b00, 2'b00, 0, 0, 1, 128'd5, 0);
        drive(2'b11, 2'b00, 0, 0, 1, 128'd1 << 63, 1);
        drive(2'b11, 2'b00, 0, 0, 1, -(128'sd1 <<< 63), 1);
        drive(2'b11, 2'b00, 0, 0, 0, 128'd1 << 64, 0);
        drive(2'b11, 2'b00, 0, 0, 0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 1);
        drive(2'b01, 2'b00, 0, 0, 1, -128'sd32769, 0);
        // random stretch
        for (int k = 0; k < 3000; k++) begin
            logic signed [127:0] w;
            w = {$urandom, $urandom, $urandom, $urandom};
            w = w >>> ($urandom % 128);
            drive(2'($urandom), 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                  1'($urandom), w, ($urandom % 8) == 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule